// File: doc/BRIEF.md
# Block Lock Write Protection Controller

This block decides whether a pending write may go ahead, for either a 32K x 8 byte array or the small status register that sets how much of that array is locked. It keeps a write enable latch and a three-bit lock code. It also samples an active-low hardware lock pin and a power-good level. Serial command decoding and the actual nonvolatile programming sit outside the block. The host logic raises one-cycle strobes and reads back single-cycle grant or deny pulses.

The locked region always starts at address 0 and grows upward. The lock code selects the size of that region. While the hardware lock pin is held low, the lock code cannot be rewritten. Every write attempt, granted or refused, clears the enable latch. A new enable command is therefore needed before each write.

Top module: `blk_lock_guard`

## Requirements
- R1: While `rst` is high at a clock edge, `we_latch` becomes 0, `lock_code` becomes `LOCK_INIT` (default 3'b000) and all four grant/deny outputs become 0.
- R2: A `we_set` strobe sets `we_latch` at the clock edge if `pwr_good` is high. A `we_clr` strobe clears it at the clock edge.
- R3: A `data_wr` strobe while `we_latch` is 0 gives `data_deny` high for the cycle after the edge. `data_grant` stays low.
- R4: The lock code gives a protected byte limit: 000 gives 0, 001 gives 64, 010 gives 128, 011 gives 256, 100 gives 512, 101 gives 8192, 110 gives 16384 and 111 gives 32768. A data write with `we_latch`=1 and `pwr_good`=1 is granted when `wr_addr` is at or above the limit and denied when it is below.
- R5: Every `data_wr` or `stat_wr` strobe, whether granted or denied, leaves `we_latch` at 0 after the edge.
- R6: A `stat_wr` strobe while `hw_lock_n` is 0 gives `stat_deny` and leaves `lock_code` unchanged.
- R7: A `stat_wr` strobe with `we_latch`=1, `hw_lock_n`=1 and `pwr_good`=1 gives `stat_grant`. In that same cycle `lock_code` shows the value `stat_din` had at the edge. `lock_code` changes at no other time.
- R8: While `pwr_good` is 0, every write is denied, `we_latch` is cleared at the next edge and `we_set` has no effect.
- R9: When several strobes are high at one edge, only one of them is acted on. The order of precedence is `data_wr`, then `stat_wr`, then `we_clr`, then `we_set`.
- R10: `addr_ok` shows, without a clock delay, whether a data write to `wr_addr` would be granted now. `stat_ok` does the same for a status write.
- R11: Each grant or deny output is high for exactly one cycle per strobe. At most one of the four is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply in range; low inhibits all writes |
| hw_lock_n | input | 1 | Hardware lock pin, active low, freezes the status register |
| we_set | input | 1 | Strobe: set the write enable latch |
| we_clr | input | 1 | Strobe: clear the write enable latch |
| stat_wr | input | 1 | Strobe: write the lock code |
| data_wr | input | 1 | Strobe: write a page to the array |
| stat_din | input | 3 | New lock code for a status write |
| wr_addr | input | ADDR_W | Start address of a data write |
| we_latch | output | 1 | Write enable latch state |
| lock_code | output | 3 | Current lock code |
| addr_ok | output | 1 | Data write to `wr_addr` would be granted now |
| stat_ok | output | 1 | Status write would be granted now |
| data_grant | output | 1 | Data write accepted (one cycle) |
| data_deny | output | 1 | Data write refused (one cycle) |
| stat_grant | output | 1 | Status write accepted (one cycle) |
| stat_deny | output | 1 | Status write refused (one cycle) |

## Verification
The properties watch every cycle for the following:
- the four pulses are mutually exclusive;
- the latch is clear after any verdict and whenever power was low;
- a grant is never given without the latch, the pin or power;
- the lowest page is never granted under a nonzero code;
- the lock code moves only together with a status grant.

The exact limit for each of the eight codes, on both sides of the boundary, is shown only by the bench's table walk. The same holds for strobe precedence and for the rule that `we_set` is ignored while power is low.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    localparam int LOCK_W = 3;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SET,
        OP_CLR,
        OP_STAT,
        OP_DATA
    } op_e;

    typedef struct packed {
        logic data_grant;
        logic data_deny;
        logic stat_grant;
        logic stat_deny;
    } verdict_t;

endpackage

// File: rtl/blk_lock_op_pick.sv
module blk_lock_op_pick
    import blk_lock_pkg::*;
(
    input  logic we_set,
    input  logic we_clr,
    input  logic stat_wr,
    input  logic data_wr,
    output op_e  op
);
    // Precedence: data write, status write, clear, set
    always_comb begin
        if (data_wr)      op = OP_DATA;
        else if (stat_wr) op = OP_STAT;
        else if (we_clr)  op = OP_CLR;
        else if (we_set)  op = OP_SET;
        else              op = OP_IDLE;
    end
endmodule

// File: rtl/blk_lock_region.sv
module blk_lock_region
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic [LOCK_W-1:0] code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam logic [ADDR_W:0] ONE = (ADDR_W+1)'(1);

    logic [ADDR_W:0] limit;

    always_comb begin
        unique case (code)
            3'd0: limit = '0;
            3'd1: limit = ONE << PAGE_W;
            3'd2: limit = ONE << (PAGE_W + 1);
            3'd3: limit = ONE << (PAGE_W + 2);
            3'd4: limit = ONE << (PAGE_W + 3);
            3'd5: limit = ONE << (ADDR_W - 2);
            3'd6: limit = ONE << (ADDR_W - 1);
            default: limit = ONE << ADDR_W;
        endcase
    end

    assign locked = {1'b0, addr} < limit;
endmodule

// File: rtl/blk_lock_state.sv
module blk_lock_state
    import blk_lock_pkg::*;
#(
    parameter logic [LOCK_W-1:0] LOCK_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              pwr_good,
    input  logic              hw_lock_n,
    input  logic              in_locked,
    input  logic [LOCK_W-1:0] stat_din,
    output logic              we_q,
    output logic [LOCK_W-1:0] code_q,
    output verdict_t          verdict_q
);
    logic              we_d;
    logic [LOCK_W-1:0] code_d;
    verdict_t          verdict_d;
    logic              stat_pass;
    logic              data_pass;

    assign stat_pass = we_q & pwr_good & hw_lock_n;
    assign data_pass = we_q & pwr_good & ~in_locked;

    always_comb begin
        we_d      = we_q & pwr_good;
        code_d    = code_q;
        verdict_d = '0;
        unique case (op)
            OP_SET: we_d = pwr_good;
            OP_CLR: we_d = 1'b0;
            OP_STAT: begin
                we_d = 1'b0;
                if (stat_pass) begin
                    code_d               = stat_din;
                    verdict_d.stat_grant = 1'b1;
                end else begin
                    verdict_d.stat_deny = 1'b1;
                end
            end
            OP_DATA: begin
                we_d                 = 1'b0;
                verdict_d.data_grant = data_pass;
                verdict_d.data_deny  = ~data_pass;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b0;
            code_q    <= LOCK_INIT;
            verdict_q <= '0;
        end else begin
            we_q      <= we_d;
            code_q    <= code_d;
            verdict_q <= verdict_d;
        end
    end
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
    import blk_lock_pkg::*;
#(
    parameter int                ADDR_W    = 15,
    parameter int                PAGE_W    = 6,
    parameter logic [LOCK_W-1:0] LOCK_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              hw_lock_n,
    input  logic              we_set,
    input  logic              we_clr,
    input  logic              stat_wr,
    input  logic              data_wr,
    input  logic [LOCK_W-1:0] stat_din,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              we_latch,
    output logic [LOCK_W-1:0] lock_code,
    output logic              addr_ok,
    output logic              stat_ok,
    output logic              data_grant,
    output logic              data_deny,
    output logic              stat_grant,
    output logic              stat_deny
);
    op_e      op;
    logic     in_locked;
    verdict_t verdict;

    blk_lock_op_pick u_pick (
        .we_set (we_set),
        .we_clr (we_clr),
        .stat_wr(stat_wr),
        .data_wr(data_wr),
        .op     (op)
    );

    blk_lock_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .code  (lock_code),
        .addr  (wr_addr),
        .locked(in_locked)
    );

    blk_lock_state #(.LOCK_INIT(LOCK_INIT)) u_state (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .pwr_good (pwr_good),
        .hw_lock_n(hw_lock_n),
        .in_locked(in_locked),
        .stat_din (stat_din),
        .we_q     (we_latch),
        .code_q   (lock_code),
        .verdict_q(verdict)
    );

    assign addr_ok    = we_latch & pwr_good & ~in_locked;
    assign stat_ok    = we_latch & pwr_good & hw_lock_n;
    assign data_grant = verdict.data_grant;
    assign data_deny  = verdict.data_deny;
    assign stat_grant = verdict.stat_grant;
    assign stat_deny  = verdict.stat_deny;
endmodule

// File: rtl/blk_lock_guard_chk.sv
module blk_lock_guard_chk #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_good,
    input logic              hw_lock_n,
    input logic              data_wr,
    input logic [2:0]        stat_din,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              we_latch,
    input logic [2:0]        lock_code,
    input logic              data_grant,
    input logic              data_deny,
    input logic              stat_grant,
    input logic              stat_deny
);
    localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_W;

    a_r11_one_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_grant, data_deny, stat_grant, stat_deny}));

    a_r5_latch_drops: assert property (@(posedge clk) disable iff (rst)
        (data_grant || data_deny || stat_grant || stat_deny) |-> !we_latch);

    a_r8_power_clears: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!we_latch && !data_grant && !stat_grant));

    a_r3_grant_needs_latch: assert property (@(posedge clk) disable iff (rst)
        data_grant |-> ($past(data_wr) && $past(we_latch)));

    a_r6_pin_blocks: assert property (@(posedge clk) disable iff (rst)
        stat_grant |-> ($past(hw_lock_n) && $past(we_latch) && $past(pwr_good)));

    a_r7_code_follows: assert property (@(posedge clk) disable iff (rst)
        stat_grant |-> (lock_code == $past(stat_din)));

    a_r7_code_still: assert property (@(posedge clk) disable iff (rst)
        !stat_grant |-> $stable(lock_code));

    a_r4_first_page: assert property (@(posedge clk) disable iff (rst)
        ($past(data_wr) && ($past(wr_addr) < PAGE_BYTES) && ($past(lock_code) != 3'd0))
            |-> !data_grant);
endmodule

bind blk_lock_guard blk_lock_guard_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .hw_lock_n (hw_lock_n),
    .data_wr   (data_wr),
    .stat_din  (stat_din),
    .wr_addr   (wr_addr),
    .we_latch  (we_latch),
    .lock_code (lock_code),
    .data_grant(data_grant),
    .data_deny (data_deny),
    .stat_grant(stat_grant),
    .stat_deny (stat_deny)
);

// File: tb/blk_lock_guard_tb_top.sv
module blk_lock_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // fields: [18:16] lock code, [15:1] address, [0] expect deny
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd0, 15'd0,     1'b0},
        {3'd1, 15'd63,    1'b1}, {3'd1, 15'd64,    1'b0},
        {3'd2, 15'd127,   1'b1}, {3'd2, 15'd128,   1'b0},
        {3'd3, 15'd255,   1'b1}, {3'd3, 15'd256,   1'b0},
        {3'd4, 15'd511,   1'b1}, {3'd4, 15'd512,   1'b0},
        {3'd5, 15'd8191,  1'b1}, {3'd5, 15'd8192,  1'b0},
        {3'd6, 15'd16383, 1'b1}, {3'd6, 15'd16384, 1'b0},
        {3'd7, 15'd32767, 1'b1}, {3'd7, 15'd0,     1'b1},
        {3'd0, 15'd32767, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_good = 1'b1;
    logic        hw_lock_n = 1'b1;
    logic        we_set = 1'b0, we_clr = 1'b0, stat_wr = 1'b0, data_wr = 1'b0;
    logic [2:0]  stat_din = '0;
    logic [14:0] wr_addr = '0;
    logic        we_latch, addr_ok, stat_ok;
    logic [2:0]  lock_code;
    logic        data_grant, data_deny, stat_grant, stat_deny;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_lock_guard dut_i (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .hw_lock_n(hw_lock_n),
        .we_set(we_set), .we_clr(we_clr), .stat_wr(stat_wr), .data_wr(data_wr),
        .stat_din(stat_din), .wr_addr(wr_addr), .we_latch(we_latch),
        .lock_code(lock_code), .addr_ok(addr_ok), .stat_ok(stat_ok),
        .data_grant(data_grant), .data_deny(data_deny),
        .stat_grant(stat_grant), .stat_deny(stat_deny)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Raise the given strobes for one edge; return at the following negedge
    task automatic strobe(input bit s_set, input bit s_clr, input bit s_stat, input bit s_data);
        @(negedge clk);
        we_set = s_set; we_clr = s_clr; stat_wr = s_stat; data_wr = s_data;
        @(negedge clk);
        we_set = 1'b0; we_clr = 1'b0; stat_wr = 1'b0; data_wr = 1'b0;
    endtask

    task automatic load_code(input logic [2:0] c);
        strobe(1, 0, 0, 0);
        stat_din = c;
        strobe(0, 0, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "we_latch", int'(we_latch), 0);
        chk("R1", "lock_code", int'(lock_code), 0);
        chk("R1", "pulses", int'({data_grant, data_deny, stat_grant, stat_deny}), 0);
        rst = 1'b0;

        // R3 write with latch clear
        wr_addr = 15'd1000;
        strobe(0, 0, 0, 1);
        chk("R3", "data_deny", int'(data_deny), 1);
        chk("R3", "data_grant", int'(data_grant), 0);
        @(negedge clk);
        chk("R11", "deny width", int'(data_deny), 0);

        // R2 set then clear
        strobe(1, 0, 0, 0);
        chk("R2", "latch set", int'(we_latch), 1);
        strobe(0, 1, 0, 0);
        chk("R2", "latch clear", int'(we_latch), 0);

        // R4 / R5 / R7 / R10 table walk
        for (int i = 0; i < NVEC; i++) begin
            load_code(VEC[i][18:16]);
            chk("R7", "code loaded", int'(lock_code), int'(VEC[i][18:16]));
            chk("R7", "stat_grant", int'(stat_grant), 1);
            chk("R5", "latch after stat", int'(we_latch), 0);
            wr_addr = VEC[i][15:1];
            strobe(1, 0, 0, 0);
            chk("R10", "addr_ok", int'(addr_ok), int'(!VEC[i][0]));
            strobe(0, 0, 0, 1);
            chk("R4", $sformatf("deny code %0d addr %0d", VEC[i][18:16], VEC[i][15:1]),
                int'(data_deny), int'(VEC[i][0]));
            chk("R4", "grant", int'(data_grant), int'(!VEC[i][0]));
            chk("R5", "latch after data", int'(we_latch), 0);
        end

        // R6 pin low refuses status write
        load_code(3'd2);
        hw_lock_n = 1'b0;
        strobe(1, 0, 0, 0);
        chk("R10", "stat_ok pin low", int'(stat_ok), 0);
        stat_din = 3'd7;
        strobe(0, 0, 1, 0);
        chk("R6", "stat_deny", int'(stat_deny), 1);
        chk("R6", "code kept", int'(lock_code), 2);
        chk("R5", "latch after refused stat", int'(we_latch), 0);
        hw_lock_n = 1'b1;

        // R8 power low
        strobe(1, 0, 0, 0);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R8", "latch cleared", int'(we_latch), 0);
        strobe(1, 0, 0, 0);
        chk("R8", "set ignored", int'(we_latch), 0);
        wr_addr = 15'd30000;
        strobe(0, 0, 0, 1);
        chk("R8", "data denied", int'(data_deny), 1);
        pwr_good = 1'b1;

        // R9 precedence
        strobe(1, 1, 0, 0);
        chk("R9", "clear beats set", int'(we_latch), 0);
        strobe(1, 0, 0, 1);
        chk("R9", "data beats set", int'(data_deny), 1);
        chk("R9", "latch after data+set", int'(we_latch), 0);
        load_code(3'd0);
        strobe(1, 0, 0, 0);
        stat_din = 3'd7;
        wr_addr = 15'd5;
        strobe(0, 0, 1, 1);
        chk("R9", "data wins over stat", int'(data_grant), 1);
        chk("R9", "no stat verdict", int'(stat_grant | stat_deny), 0);
        chk("R9", "code untouched", int'(lock_code), 0);

        // R1 reset again with state set
        load_code(3'd5);
        strobe(1, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "reset latch", int'(we_latch), 0);
        chk("R1", "reset code", int'(lock_code), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule